// File: doc/BRIEF.md
# High-Speed Transmit Slew-Rate Calibration Sequencer

This block runs the whole slew-rate trim of one high-speed USB 2.0 transmitter without software help. A single start pulse makes it power the port's ring oscillator, let it settle, bring up a free-running clock for the shared frequency meter, and program that meter with a fixed measurement window and the channel of the port being trimmed. It then arms the meter and waits until either the meter reports a result or a timeout runs out.

The raw count is turned into a 3-bit drive code. A shared restoring divider runs twice: first it divides the constant window × reference-MHz × 28 by the count, then it divides that result plus one half of 1000 by 1000, which rounds to the nearest integer. Only the low three bits of the result are kept. A zero count, which a failed measurement produces, bypasses the divider and yields code 4. Teardown follows a fixed order: the meter is disabled, then the free-running clock is stopped, then the code is written to the port, and only after that write is the oscillator switched off. A done pulse closes the run, with the code still present on its output.

Top module: `srcal_seq`

## Requirements
- R1: After reset, every enable, strobe and flag output is low and `code_o` is 0.
- R2: A `start_i` pulse while idle starts a run and latches `chan_i`. A `start_i` pulse during a run has no effect: neither the channel of the running sequence changes nor does a second run follow.
- R3: `frck_en_o` rises no earlier than `SETTLE_CYC` cycles after `osc_en_o` rises.
- R4: The free-run clock comes on first. After it, `fm_cfg_we_o` pulses with `fm_window_o` = `WINDOW` (1024) and `fm_chan_o` = the latched channel, and only after that does `fm_en_o` rise.
- R5: While the meter is enabled, `fm_valid_i` high ends the wait, `fm_count_i` is taken as the result, and `fm_en_o` falls within 3 cycles of `fm_valid_i`.
- R6: If `fm_valid_i` stays low, the wait ends after `TIMEOUT_CYC` cycles and `fm_count_i` is used anyway.
- R7: `fm_en_o` falls before `frck_en_o` falls, and both are low before `slew_we_o` pulses.
- R8: For a nonzero count N, the code equals ((745472 / N) + 500) / 1000 (integer division) modulo 8.
- R9: A count of zero gives code 4.
- R10: Only the low 3 bits of the rounded result reach `code_o`. For example, N = 1 gives 745 mod 8 = 1.
- R11: `slew_we_o` pulses with the new code on `code_o`. `osc_en_o` falls after that pulse, `done_o` pulses after `osc_en_o` is low, and `code_o` holds the code at `done_o`.
- R12: `busy_o` is high from the cycle after start until `done_o`, and in every cycle where `osc_en_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| chan_i | input | CH_W | Meter channel of the port under trim |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| code_o | output | CODE_W | Calibrated slew-rate code |
| slew_we_o | output | 1 | Write strobe for the port's slew field |
| osc_en_o | output | 1 | Ring oscillator enable |
| frck_en_o | output | 1 | Free-running meter clock enable |
| fm_cfg_we_o | output | 1 | Meter configuration write strobe |
| fm_window_o | output | WIN_W | Measurement window in reference cycles |
| fm_chan_o | output | CH_W | Meter channel select |
| fm_en_o | output | 1 | Meter enable |
| fm_valid_i | input | 1 | Meter result valid |
| fm_count_i | input | RES_W | Meter result |

## Verification
The hardest path to reach from the ports is a measurement that never finishes. Here the meter stays silent for the full timeout, and a stale count must still go through the formula. The bench holds `fm_valid_i` low for an entire run with a preset count. Separate directed runs use counts of 0 and 1, plus counts placed one step either side of a rounding boundary (496 and 497). Random runs vary the count and the valid delay, and one run fires a second start with a different channel in the middle of the sequence.

// File: rtl/srcal_pkg.sv
package srcal_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_CFG,
      ST_ARM,
      ST_WAIT,
      ST_STOPM,
      ST_STOPC,
      ST_DIVA,
      ST_DIVB,
      ST_WRITE,
      ST_OSCOFF,
      ST_FIN
   } srcal_st_e;

endpackage

// File: rtl/srcal_tick.sv
module srcal_tick #(
   parameter int W = 13
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld_i,
   input  logic [W-1:0] val_i,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (ld_i)
         cnt_q <= val_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/srcal_div.sv
module srcal_div #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go_i,
   input  logic [W-1:0] num_i,
   input  logic [W-1:0] den_i,
   output logic         done_o,
   output logic [W-1:0] quo_o
);

   localparam int CW = $clog2(W + 1);

   if (W < 2) begin : g_bad_w
      $error("srcal_div: W must be at least 2");
   end

   logic [W-1:0]  rem_q, quo_q, den_q;
   logic [CW-1:0] left_q;
   logic          run_q, done_q;
   logic [W:0]    trial, diff;
   logic          fits;

   assign trial = {rem_q, quo_q[W-1]};
   assign diff  = trial - {1'b0, den_q};
   assign fits  = (trial >= {1'b0, den_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         quo_q  <= '0;
         den_q  <= '0;
         left_q <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else if (go_i) begin
         rem_q  <= '0;
         quo_q  <= num_i;
         den_q  <= den_i;
         left_q <= CW'(W);
         run_q  <= 1'b1;
         done_q <= 1'b0;
      end else if (run_q) begin
         rem_q  <= fits ? diff[W-1:0] : trial[W-1:0];
         quo_q  <= {quo_q[W-2:0], fits};
         left_q <= left_q - 1'b1;
         run_q  <= (left_q != CW'(1));
         done_q <= (left_q == CW'(1));
      end else begin
         done_q <= 1'b0;
      end
   end

   assign done_o = done_q;
   assign quo_o  = quo_q;

   // R8
   rem_below_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (rem_q < den_q));

   // R9
   no_zero_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (den_q != '0));

endmodule

// File: rtl/srcal_seq.sv
module srcal_seq
   import srcal_pkg::*;
#(
   parameter int REF_MHZ      = 26,
   parameter int WINDOW       = 1024,
   parameter int SR_COEF      = 28,
   parameter int SR_DIV       = 1000,
   parameter int SETTLE_CYC   = 26,
   parameter int TIMEOUT_CYC  = 5200,
   parameter int RES_W        = 32,
   parameter int WIN_W        = 24,
   parameter int CH_W         = 2,
   parameter int CODE_W       = 3,
   parameter int DEFAULT_CODE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CH_W-1:0]   chan_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [CODE_W-1:0] code_o,
   output logic              slew_we_o,
   output logic              osc_en_o,
   output logic              frck_en_o,
   output logic              fm_cfg_we_o,
   output logic [WIN_W-1:0]  fm_window_o,
   output logic [CH_W-1:0]   fm_chan_o,
   output logic              fm_en_o,
   input  logic              fm_valid_i,
   input  logic [RES_W-1:0]  fm_count_i
);

   localparam int NUMER   = WINDOW * REF_MHZ * SR_COEF;
   localparam int BIAS    = SR_DIV / 2;
   localparam int TMR_MAX = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
   localparam int TMR_W   = $clog2(TMR_MAX + 1);
   localparam int SCK_W   = TMR_W + 1;

   // elaboration-time parameter checks
   if (CODE_W < 1 || CODE_W > RES_W) begin : g_bad_code_w
      $error("srcal_seq: CODE_W out of range");
   end
   if (DEFAULT_CODE < 0 || DEFAULT_CODE >= (1 << CODE_W)) begin : g_bad_default
      $error("srcal_seq: DEFAULT_CODE does not fit CODE_W");
   end
   if ($clog2(NUMER + BIAS + 1) > RES_W) begin : g_bad_res_w
      $error("srcal_seq: RES_W too narrow for the numerator");
   end
   if ($clog2(WINDOW + 1) > WIN_W) begin : g_bad_win_w
      $error("srcal_seq: WIN_W too narrow for WINDOW");
   end
   if (SETTLE_CYC < 1 || TIMEOUT_CYC < 1 || SR_DIV < 1) begin : g_bad_time
      $error("srcal_seq: cycle counts and divisor must be positive");
   end

   srcal_st_e         st_q;
   logic [CH_W-1:0]   chan_q;
   logic [RES_W-1:0]  count_q;
   logic [CODE_W-1:0] code_q;
   logic              busy_q, done_q, slew_we_q, osc_q, frck_q, cfg_we_q, fm_en_q;

   // shared timer: settle window, then meter timeout
   logic             tmr_ld;
   logic [TMR_W-1:0] tmr_val;
   logic             tmr_zero;

   always_comb begin
      tmr_ld  = 1'b0;
      tmr_val = TMR_W'(TIMEOUT_CYC);
      if (st_q == ST_IDLE && start_i) begin
         tmr_ld  = 1'b1;
         tmr_val = TMR_W'(SETTLE_CYC);
      end else if (st_q == ST_ARM) begin
         tmr_ld  = 1'b1;
      end
   end

   srcal_tick #(.W(TMR_W)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_i   (tmr_ld),
      .val_i  (tmr_val),
      .zero_o (tmr_zero)
   );

   // shared divider: count division, then rounding division
   logic             div_go;
   logic [RES_W-1:0] div_num, div_den;
   logic             div_done;
   logic [RES_W-1:0] div_quo;

   srcal_div #(.W(RES_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (div_go),
      .num_i  (div_num),
      .den_i  (div_den),
      .done_o (div_done),
      .quo_o  (div_quo)
   );

   logic [CODE_W-1:0] quo_code;
   assign quo_code = div_quo[CODE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         chan_q    <= '0;
         count_q   <= '0;
         code_q    <= '0;
         busy_q    <= 1'b0;
         done_q    <= 1'b0;
         slew_we_q <= 1'b0;
         osc_q     <= 1'b0;
         frck_q    <= 1'b0;
         cfg_we_q  <= 1'b0;
         fm_en_q   <= 1'b0;
         div_go    <= 1'b0;
         div_num   <= '0;
         div_den   <= '0;
      end else begin
         cfg_we_q  <= 1'b0;
         slew_we_q <= 1'b0;
         done_q    <= 1'b0;
         div_go    <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  chan_q <= chan_i;
                  osc_q  <= 1'b1;
                  busy_q <= 1'b1;
                  st_q   <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               if (tmr_zero) begin
                  frck_q <= 1'b1;
                  st_q   <= ST_CFG;
               end
            end
            ST_CFG: begin
               cfg_we_q <= 1'b1;
               st_q     <= ST_ARM;
            end
            ST_ARM: begin
               fm_en_q <= 1'b1;
               st_q    <= ST_WAIT;
            end
            ST_WAIT: begin
               if (fm_valid_i || tmr_zero) begin
                  count_q <= fm_count_i;
                  st_q    <= ST_STOPM;
               end
            end
            ST_STOPM: begin
               fm_en_q <= 1'b0;
               st_q    <= ST_STOPC;
            end
            ST_STOPC: begin
               frck_q <= 1'b0;
               if (count_q == '0) begin
                  code_q <= CODE_W'(DEFAULT_CODE);
                  st_q   <= ST_WRITE;
               end else begin
                  div_num <= RES_W'(NUMER);
                  div_den <= count_q;
                  div_go  <= 1'b1;
                  st_q    <= ST_DIVA;
               end
            end
            ST_DIVA: begin
               if (div_done) begin
                  div_num <= div_quo + RES_W'(BIAS);
                  div_den <= RES_W'(SR_DIV);
                  div_go  <= 1'b1;
                  st_q    <= ST_DIVB;
               end
            end
            ST_DIVB: begin
               if (div_done) begin
                  code_q <= quo_code;
                  st_q   <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               slew_we_q <= 1'b1;
               st_q      <= ST_OSCOFF;
            end
            ST_OSCOFF: begin
               osc_q <= 1'b0;
               st_q  <= ST_FIN;
            end
            ST_FIN: begin
               done_q <= 1'b1;
               busy_q <= 1'b0;
               st_q   <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o      = busy_q;
   assign done_o      = done_q;
   assign code_o      = code_q;
   assign slew_we_o   = slew_we_q;
   assign osc_en_o    = osc_q;
   assign frck_en_o   = frck_q;
   assign fm_cfg_we_o = cfg_we_q;
   assign fm_window_o = WIN_W'(WINDOW);
   assign fm_chan_o   = chan_q;
   assign fm_en_o     = fm_en_q;

   // checker-side settle counter
   logic [SCK_W-1:0] settle_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         settle_cnt <= '0;
      else if (!osc_en_o)
         settle_cnt <= '0;
      else if (!frck_en_o && settle_cnt != '1)
         settle_cnt <= settle_cnt + 1'b1;
   end

   // R3
   settle_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frck_en_o) |-> (settle_cnt >= SCK_W'(SETTLE_CYC)));

   // R7
   meter_needs_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fm_en_o |-> frck_en_o);

   // R7
   clock_needs_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frck_en_o |-> osc_en_o);

   // R7
   write_after_teardown_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slew_we_o |-> (!fm_en_o && !frck_en_o && osc_en_o));

   // R11
   write_before_osc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(osc_en_o) |-> $past(slew_we_o));

   // R11
   done_after_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!osc_en_o && !busy_o));

   // R12
   busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      osc_en_o |-> busy_o);

   // R2
   chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(fm_chan_o));

endmodule

// File: tb/sim_srcal_seq.sv
module sim_srcal_seq;

   localparam int SETTLE  = 26;
   localparam int TIMEOUT = 5200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  chan_i = 2'd0;
   logic        busy_o, done_o, slew_we_o, osc_en_o, frck_en_o, fm_cfg_we_o, fm_en_o;
   logic [2:0]  code_o;
   logic [23:0] fm_window_o;
   logic [1:0]  fm_chan_o;
   logic        fm_valid_i = 1'b0;
   logic [31:0] fm_count_i = 32'd0;

   int n_run  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   srcal_seq u0 (
      .clk (clk), .rst_n (rst_n), .start_i (start_i), .chan_i (chan_i),
      .busy_o (busy_o), .done_o (done_o), .code_o (code_o), .slew_we_o (slew_we_o),
      .osc_en_o (osc_en_o), .frck_en_o (frck_en_o), .fm_cfg_we_o (fm_cfg_we_o),
      .fm_window_o (fm_window_o), .fm_chan_o (fm_chan_o), .fm_en_o (fm_en_o),
      .fm_valid_i (fm_valid_i), .fm_count_i (fm_count_i)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_code(input int unsigned cnt);
      int unsigned q;
      if (cnt == 0) return 4;
      q = 745472 / cnt;
      return int'(((q + 500) / 1000) & 7);
   endfunction

   // event monitor, sampled at the falling edge
   longint t_osc_r, t_frck_r, t_cfg, t_fmen_r, t_fmen_f, t_frck_f, t_we, t_osc_f, t_done;
   int     cfg_win, cfg_chan, we_code, done_code;
   bit     busy_gap;
   logic   p_osc = 0, p_frck = 0, p_fmen = 0;

   always @(negedge clk) begin
      longint c;
      c = longint'($time / 10);
      if (osc_en_o && !p_osc) t_osc_r = c;
      if (!osc_en_o && p_osc) t_osc_f = c;
      if (frck_en_o && !p_frck) t_frck_r = c;
      if (!frck_en_o && p_frck) t_frck_f = c;
      if (fm_en_o && !p_fmen) t_fmen_r = c;
      if (!fm_en_o && p_fmen) t_fmen_f = c;
      if (fm_cfg_we_o) begin
         t_cfg = c; cfg_win = int'(fm_window_o); cfg_chan = int'(fm_chan_o);
      end
      if (slew_we_o) begin t_we = c; we_code = int'(code_o); end
      if (done_o) begin t_done = c; done_code = int'(code_o); end
      if (osc_en_o && !busy_o) busy_gap = 1'b1;
      p_osc = osc_en_o; p_frck = frck_en_o; p_fmen = fm_en_o;
   end

   task automatic run_one(input int unsigned cnt, input int dly, input bit tmo,
                          input bit extra_start, input logic [1:0] ch);
      longint t_valid;
      int     e;
      t_valid = 0;
      busy_gap = 1'b0;
      e = exp_code(cnt);
      @(negedge clk);
      start_i = 1'b1; chan_i = ch;
      if (tmo) fm_count_i = cnt;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R12 busy after start", longint'(busy_o), 1);
      while (!fm_en_o) @(negedge clk);
      if (extra_start) begin
         start_i = 1'b1; chan_i = ~ch;
         @(negedge clk);
         start_i = 1'b0;
      end
      if (!tmo) begin
         repeat (dly) @(negedge clk);
         fm_count_i = cnt; fm_valid_i = 1'b1;
         t_valid = longint'($time / 10);
      end
      while (fm_en_o) @(negedge clk);
      fm_valid_i = 1'b0;
      while (!done_o) @(negedge clk);
      @(negedge clk);
      chk(t_frck_r - t_osc_r >= SETTLE, "R3 settle", t_frck_r - t_osc_r, SETTLE);
      chk(t_cfg > t_frck_r && t_fmen_r > t_cfg, "R4 order", t_cfg, t_frck_r + 1);
      chk(cfg_win == 1024, "R4 window", cfg_win, 1024);
      chk(cfg_chan == int'(ch), "R4 channel", cfg_chan, int'(ch));
      if (extra_start) chk(cfg_chan == int'(ch), "R2 channel kept", cfg_chan, int'(ch));
      if (tmo)
         chk(t_fmen_f - t_fmen_r >= TIMEOUT, "R6 timeout", t_fmen_f - t_fmen_r, TIMEOUT);
      else
         chk(t_fmen_f > t_valid && t_fmen_f - t_valid <= 3, "R5 valid ends wait",
             t_fmen_f - t_valid, 2);
      chk(t_fmen_f < t_frck_f && t_frck_f < t_we, "R7 teardown order", t_frck_f, t_we);
      if (cnt == 0)
         chk(we_code == 4, "R9 zero default", we_code, 4);
      else if (cnt == 1)
         chk(we_code == e, "R10 low bits", we_code, e);
      else
         chk(we_code == e, "R8 code", we_code, e);
      chk(t_we < t_osc_f && t_osc_f < t_done, "R11 osc off after write", t_osc_f, t_we + 1);
      chk(done_code == e, "R11 code held at done", done_code, e);
      chk(!busy_gap && !busy_o, "R12 busy cover", longint'(busy_gap), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      chk({busy_o, done_o, osc_en_o, frck_en_o, fm_en_o, fm_cfg_we_o, slew_we_o} == 7'd0,
          "R1 outputs in reset", longint'({busy_o, osc_en_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(code_o == 3'd0 && !busy_o, "R1 after reset", longint'(code_o), 0);

      run_one(186, 5, 1'b0, 1'b0, 2'd1);
      run_one(0, 3, 1'b0, 1'b0, 2'd2);
      run_one(1, 1, 1'b0, 1'b0, 2'd3);
      run_one(496, 7, 1'b0, 1'b0, 2'd0);
      run_one(497, 7, 1'b0, 1'b0, 2'd0);
      run_one(300, 0, 1'b1, 1'b0, 2'd1);
      run_one(0, 0, 1'b1, 1'b0, 2'd2);
      run_one(149, 12, 1'b0, 1'b1, 2'd1);
      repeat (10) @(negedge clk);
      chk(!busy_o && !osc_en_o, "R2 no second run", longint'(busy_o), 0);

      for (int i = 0; i < 24; i++) begin
         int unsigned c;
         c = (i % 2 == 0) ? 100 + ($urandom % 400) : $urandom % 200000;
         run_one(c, 1 + int'($urandom % 40), 1'b0, 1'b0, 2'($urandom % 4));
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule